// File: doc/BRIEF.md
# Calendar-Day Real-Time Clock with Alarm and Tick Interrupts

This block is a memory-mapped real-time clock with a 16-bit register port. It keeps the time as a day count plus an hour, minute and second. A prescaler turns a slow reference clock into a one-second tick. The reference may run at 32768 Hz, 32000 Hz or 38400 Hz. It is presented to the block as a single-cycle strobe, `ref_pulse`, synchronous to the bus clock. The same prescaler also produces a 2 Hz tick and eight sampling ticks, from 4 Hz up to 512 Hz.

An alarm is held in the same day / hour:minute / second format as the time. Every event (alarm, 1 Hz, 2 Hz and the sampling ticks) sets a bit in a status register. Software clears a status bit by writing a one to it. The status register is ANDed with an enable register, and any bit left set drives the single interrupt line.

Software sets the time and the alarm, selects the reference rate and enables counting in the control register, and then services `irq`.

Top module: `rtc_dhms`

## Requirements
- R1: After reset every readable register is 0 and `irq` is low.
- R2: Register offsets and layouts are as follows. The upper bits of each field read as 0.
  - Time hour:minute at 0x00, with the hour in bits 12:8 and the minute in bits 5:0. The alarm hour:minute at 0x08 uses the same layout.
  - Time seconds at 0x04 and alarm seconds at 0x0C, in bits 5:0.
  - Day count at 0x20 and alarm day at 0x24, 16 bits each.
  - Control at 0x10: bit 7 enables counting, and bits 6:5 select the reference. Only these three bits are stored.
  - Interrupt enable at 0x18. Only bits 0, 2, 4, 7 and 15:8 are stored.
  - Offsets 0x1C, 0x28, 0x2C and 0x30 read as 0.
- R3: The reference select picks the number of reference pulses per second, counted from the moment counting is enabled: 00 (and 11) gives 32768, 01 gives 32000 and 10 gives 38400.
- R4: On each second, seconds roll over after 59 into minutes, minutes after 59 into hours, and hours after 23 into a day increment.
- R5: While control bit 7 is 0, the prescaler is held cleared and reference pulses are ignored. After re-enabling, a full second of pulses is needed before the next advance.
- R6: Status bit 2 (alarm) is set when a one-second advance makes day, hour, minute and second all equal the alarm registers. It is not set when they differ.
- R7: Tick status bits are at 0x14. Bit 4 is set once per second and bit 7 at 2 Hz. Bit 8+k is set at 2^(k+2) Hz, with bit 15 being the 512 Hz tick. A tick's status bit is set on the second clock edge after the reference pulse that completes it. Bit 0 never sets.
- R8: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R9: `irq` is high exactly when some status bit and the same enable bit are both 1.
- R10: When a status write clears a bit on the same edge as a new event for that bit, the bit is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | One-cycle strobe per reference clock period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt, status AND enable nonzero |

## Verification
The bench holds `ref_pulse` low while it programs registers. It then releases an exact number of reference pulses, so every expected time and status value follows from a pulse count.

The time tests stop one pulse short of a second and then apply one more pulse. This separates a correct terminal count from an off-by-one for each of the three reference rates. A start at day 5, 23:59:59 exercises every carry at once and also hits the alarm. A minute-only carry exercises the same path while the alarm does not match.

A short 64-pulse run checks the sampling-tick rates: only the two fastest sampling ticks may have fired. A clear held across the exact edge where an event lands separates "set wins" from "clear wins".

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int BUS_W = 16;
   localparam int ADR_W = 6;

   localparam logic [ADR_W-1:0] A_HM   = 6'h00;
   localparam logic [ADR_W-1:0] A_SEC  = 6'h04;
   localparam logic [ADR_W-1:0] A_AHM  = 6'h08;
   localparam logic [ADR_W-1:0] A_ASEC = 6'h0C;
   localparam logic [ADR_W-1:0] A_CTL  = 6'h10;
   localparam logic [ADR_W-1:0] A_STAT = 6'h14;
   localparam logic [ADR_W-1:0] A_IEN  = 6'h18;
   localparam logic [ADR_W-1:0] A_DAY  = 6'h20;
   localparam logic [ADR_W-1:0] A_ADAY = 6'h24;

   localparam int B_ALM  = 2;
   localparam int B_1HZ  = 4;
   localparam int B_2HZ  = 7;
   localparam int B_SMP0 = 8;
   localparam int C_EN   = 7;
   localparam int C_SEL  = 5;

   localparam logic [BUS_W-1:0] SRC_MASK = 16'hFF95;

   typedef struct packed {
      logic [4:0] hr;
      logic [5:0] mn;
      logic [5:0] sc;
   } hms_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int SUB_W   = 10,
   parameter int REF_HZ0 = 32768,
   parameter int REF_HZ1 = 32000,
   parameter int REF_HZ2 = 38400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [1:0]       sel,
   input  logic             ref_pulse,
   output logic             sec_tick,
   output logic [SUB_W-2:0] edge_tick
);
   localparam int REF_MAX = (REF_HZ0 > REF_HZ1) ?
                            ((REF_HZ0 > REF_HZ2) ? REF_HZ0 : REF_HZ2) :
                            ((REF_HZ1 > REF_HZ2) ? REF_HZ1 : REF_HZ2);
   localparam int ACC_W = $clog2(REF_MAX) + 1;
   localparam logic [ACC_W-1:0] INC = ACC_W'(2 ** SUB_W);

   if (REF_HZ0 <= 2 ** SUB_W || REF_HZ1 <= 2 ** SUB_W || REF_HZ2 <= 2 ** SUB_W) begin : g_bad_ref
      $error("each reference rate must exceed 2**SUB_W");
   end

   logic [ACC_W-1:0] acc, acc_sum, div;
   logic [SUB_W-1:0] sub, sub_nx;
   logic             step;

   always_comb begin
      case (sel)
         2'b01:   div = ACC_W'(REF_HZ1);
         2'b10:   div = ACC_W'(REF_HZ2);
         default: div = ACC_W'(REF_HZ0);
      endcase
      acc_sum = acc + INC;
      step    = ref_pulse && (acc_sum >= div);
      sub_nx  = sub + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         acc       <= '0;
         sub       <= '0;
         sec_tick  <= 1'b0;
         edge_tick <= '0;
      end else begin
         if (ref_pulse) acc <= step ? (acc_sum - div) : acc_sum;
         if (step) sub <= sub_nx;
         sec_tick  <= step && (&sub);
         edge_tick <= step ? (~sub[SUB_W-2:0] & sub_nx[SUB_W-2:0]) : '0;
      end
   end

   // R5
   held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!sec_tick && edge_tick == '0));

   // R3
   wrap_on_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> (sub == '0));
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
   import rtc_pkg::*;
#(
   parameter int DAY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_hm,
   input  logic             wr_sec,
   input  logic             wr_day,
   input  logic             wr_ahm,
   input  logic             wr_asec,
   input  logic             wr_aday,
   input  logic [BUS_W-1:0] wdata,
   output hms_t             now_hms,
   output logic [DAY_W-1:0] now_day,
   output hms_t             alm_hms,
   output logic [DAY_W-1:0] alm_day,
   output logic             alarm_evt
);
   if (DAY_W < 1 || DAY_W > BUS_W) begin : g_bad_day
      $error("DAY_W must be 1..16");
   end

   logic wr_any, c_sc, c_mn, c_hr, tick_q;

   assign wr_any = wr_hm || wr_sec || wr_day;
   assign c_sc   = now_hms.sc >= 6'd59;
   assign c_mn   = now_hms.mn >= 6'd59;
   assign c_hr   = now_hms.hr >= 5'd23;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now_hms <= '0;
         now_day <= '0;
         tick_q  <= 1'b0;
      end else begin
         tick_q <= tick && !wr_any;
         if (wr_any) begin
            if (wr_hm) begin
               now_hms.hr <= wdata[12:8];
               now_hms.mn <= wdata[5:0];
            end
            if (wr_sec) now_hms.sc <= wdata[5:0];
            if (wr_day) now_day <= wdata[DAY_W-1:0];
         end else if (tick) begin
            now_hms.sc <= c_sc ? 6'd0 : now_hms.sc + 6'd1;
            if (c_sc) now_hms.mn <= c_mn ? 6'd0 : now_hms.mn + 6'd1;
            if (c_sc && c_mn) now_hms.hr <= c_hr ? 5'd0 : now_hms.hr + 5'd1;
            if (c_sc && c_mn && c_hr) now_day <= now_day + DAY_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alm_hms <= '0;
         alm_day <= '0;
      end else begin
         if (wr_ahm) begin
            alm_hms.hr <= wdata[12:8];
            alm_hms.mn <= wdata[5:0];
         end
         if (wr_asec) alm_hms.sc <= wdata[5:0];
         if (wr_aday) alm_day <= wdata[DAY_W-1:0];
      end
   end

   assign alarm_evt = tick_q && (now_day == alm_day) && (now_hms == alm_hms);

   // R4
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_any && now_hms.sc == 6'd59) |=> (now_hms.sc == 6'd0));

   // R4
   min_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_any && now_hms.sc == 6'd59 && now_hms.mn == 6'd59) |=> (now_hms.mn == 6'd0));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
   parameter int         W    = 16,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         clr_we,
   input  logic [W-1:0] clr_data,
   input  logic         ien_we,
   input  logic [W-1:0] ien_data,
   output logic [W-1:0] stat,
   output logic [W-1:0] ien,
   output logic         irq
);
   logic [W-1:0] clr_v;

   assign clr_v = clr_we ? clr_data : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat <= '0;
         ien  <= '0;
      end else begin
         stat <= ((stat & ~clr_v) | evt) & MASK;
         if (ien_we) ien <= ien_data & MASK;
      end
   end

   assign irq = |(stat & ien);

   // R8
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((stat & $past(clr_data & ~evt)) == '0));

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt & MASK)) |=> ((stat & $past(evt & MASK)) == $past(evt & MASK)));
endmodule

// File: rtl/rtc_dhms.sv
module rtc_dhms
   import rtc_pkg::*;
#(
   parameter int DAY_W    = 16,
   parameter int N_SAMPLE = 8,
   parameter int REF_HZ0  = 32768,
   parameter int REF_HZ1  = 32000,
   parameter int REF_HZ2  = 38400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_pulse,
   input  logic             bus_wr,
   input  logic [ADR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             irq
);
   localparam int SUB_W = N_SAMPLE + 2;

   if (N_SAMPLE < 1 || N_SAMPLE > BUS_W - B_SMP0) begin : g_bad_smp
      $error("N_SAMPLE must be 1..8");
   end

   logic             ctl_en;
   logic [1:0]       ctl_sel;
   logic             sec_tick, alarm_evt;
   logic [SUB_W-2:0] edge_tick;
   logic [N_SAMPLE-1:0] smp;
   logic [BUS_W-1:0] evt, stat, ien;
   hms_t             now_hms, alm_hms;
   logic [DAY_W-1:0] now_day, alm_day;

   function automatic logic hit(input logic [ADR_W-1:0] a);
      return bus_wr && (bus_addr == a);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_en  <= 1'b0;
         ctl_sel <= 2'b00;
      end else if (hit(A_CTL)) begin
         ctl_en  <= bus_wdata[C_EN];
         ctl_sel <= bus_wdata[C_SEL+1:C_SEL];
      end
   end

   rtc_prescaler #(
      .SUB_W(SUB_W), .REF_HZ0(REF_HZ0), .REF_HZ1(REF_HZ1), .REF_HZ2(REF_HZ2)
   ) i_presc (
      .clk(clk), .rst_n(rst_n), .en(ctl_en), .sel(ctl_sel),
      .ref_pulse(ref_pulse), .sec_tick(sec_tick), .edge_tick(edge_tick)
   );

   rtc_timekeeper #(.DAY_W(DAY_W)) i_time (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick),
      .wr_hm(hit(A_HM)), .wr_sec(hit(A_SEC)), .wr_day(hit(A_DAY)),
      .wr_ahm(hit(A_AHM)), .wr_asec(hit(A_ASEC)), .wr_aday(hit(A_ADAY)),
      .wdata(bus_wdata), .now_hms(now_hms), .now_day(now_day),
      .alm_hms(alm_hms), .alm_day(alm_day), .alarm_evt(alarm_evt)
   );

   for (genvar k = 0; k < N_SAMPLE; k++) begin : g_smp
      assign smp[k] = edge_tick[SUB_W-3-k];
   end

   always_comb begin
      evt = '0;
      evt[B_ALM] = alarm_evt;
      evt[B_1HZ] = sec_tick;
      evt[B_2HZ] = edge_tick[SUB_W-2];
      evt[B_SMP0 +: N_SAMPLE] = smp;
   end

   rtc_irq_ctrl #(.W(BUS_W), .MASK(SRC_MASK)) i_irq (
      .clk(clk), .rst_n(rst_n), .evt(evt),
      .clr_we(hit(A_STAT)), .clr_data(bus_wdata),
      .ien_we(hit(A_IEN)), .ien_data(bus_wdata),
      .stat(stat), .ien(ien), .irq(irq)
   );

   always_comb begin
      case (bus_addr)
         A_HM:    bus_rdata = {3'b0, now_hms.hr, 2'b0, now_hms.mn};
         A_SEC:   bus_rdata = {10'b0, now_hms.sc};
         A_AHM:   bus_rdata = {3'b0, alm_hms.hr, 2'b0, alm_hms.mn};
         A_ASEC:  bus_rdata = {10'b0, alm_hms.sc};
         A_CTL:   bus_rdata = BUS_W'({ctl_en, ctl_sel, 5'b0});
         A_STAT:  bus_rdata = stat;
         A_IEN:   bus_rdata = ien;
         A_DAY:   bus_rdata = BUS_W'(now_day);
         A_ADAY:  bus_rdata = BUS_W'(alm_day);
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: tb/test_rtc_dhms.sv
module test_rtc_dhms;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_pulse = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;
   logic        mon_v = 1'b0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_dhms i_rtc_dhms (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: pops one expected read per strobe
   always @(negedge clk) begin
      if (mon_v && exp_q.size() > 0) begin
         logic [15:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(bus_rdata === e, t, bus_rdata, e);
      end
   end

   task automatic rd(input logic [5:0] a, input logic [15:0] e, input string t);
      @(posedge clk); #1;
      bus_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      mon_v = 1'b1;
      @(posedge clk); #1;
      mon_v = 1'b0;
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic pulses(input int n);
      @(posedge clk); #1;
      ref_pulse = 1'b1;
      repeat (n) @(posedge clk);
      #1 ref_pulse = 1'b0;
      repeat (6) @(posedge clk);
   endtask

   task automatic chk_irq(input logic e, input string t);
      @(negedge clk);
      check(irq === e, t, {15'b0, irq}, {15'b0, e});
   endtask

   initial begin
      repeat (200000 - 10000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(6'h00, 16'h0000, "R1 hm");
      rd(6'h10, 16'h0000, "R1 ctl");
      rd(6'h14, 16'h0000, "R1 stat");
      rd(6'h20, 16'h0000, "R1 day");
      chk_irq(1'b0, "R1 irq");

      // R2 layout and readback
      wr(6'h00, 16'hFFFF); rd(6'h00, 16'h1F3F, "R2 hm fields");
      wr(6'h00, 16'h1234); rd(6'h00, 16'h1234, "R2 hm");
      wr(6'h04, 16'h002A); rd(6'h04, 16'h002A, "R2 sec");
      wr(6'h20, 16'hBEEF); rd(6'h20, 16'hBEEF, "R2 day");
      wr(6'h08, 16'h0A0B); rd(6'h08, 16'h0A0B, "R2 alarm hm");
      wr(6'h0C, 16'h0007); rd(6'h0C, 16'h0007, "R2 alarm sec");
      wr(6'h24, 16'h0102); rd(6'h24, 16'h0102, "R2 alarm day");
      wr(6'h10, 16'hFFFF); rd(6'h10, 16'h00E0, "R2 ctl");
      wr(6'h10, 16'h0000);
      wr(6'h18, 16'hFFFF); rd(6'h18, 16'hFF95, "R2 ien");
      wr(6'h18, 16'h0000);
      wr(6'h1C, 16'hFFFF); rd(6'h1C, 16'h0000, "R2 stopwatch");
      rd(6'h28, 16'h0000, "R2 test reg");

      // R7 sampling rates: 64 pulses at 32768 -> only 512 Hz and 256 Hz ticks
      wr(6'h10, 16'h0080);
      pulses(64);
      rd(6'h14, 16'hC000, "R7 fast samples");
      // R8 write-one-to-clear
      wr(6'h14, 16'h4000); rd(6'h14, 16'h8000, "R8 clear one");
      wr(6'h14, 16'h0000); rd(6'h14, 16'h8000, "R8 zero no effect");
      wr(6'h14, 16'h8000); rd(6'h14, 16'h0000, "R8 clear rest");

      // R10 clear held across the landing edge of the next 512 Hz event
      @(posedge clk); #1;
      ref_pulse = 1'b1; bus_wr = 1'b1; bus_addr = 6'h14; bus_wdata = 16'hFFFF;
      repeat (32) @(posedge clk);
      #1 ref_pulse = 1'b0;
      @(posedge clk); #1 bus_wr = 1'b0;
      rd(6'h14, 16'h8000, "R10 set wins");
      wr(6'h14, 16'hFFFF);

      // R3/R4/R6: 96 pulses used, 32672 left in this second
      wr(6'h20, 16'h0005); wr(6'h00, 16'h173B); wr(6'h04, 16'h003B);
      wr(6'h24, 16'h0006); wr(6'h08, 16'h0000); wr(6'h0C, 16'h0000);
      wr(6'h18, 16'h0004);
      pulses(32671);
      rd(6'h04, 16'h003B, "R3 one short of 32768");
      pulses(1);
      rd(6'h04, 16'h0000, "R4 sec wrap");
      rd(6'h00, 16'h0000, "R4 hour and minute wrap");
      rd(6'h20, 16'h0006, "R4 day carry");
      rd(6'h14, 16'hFF94, "R6 R7 status after second");
      chk_irq(1'b1, "R9 alarm enabled");
      wr(6'h18, 16'h0000); chk_irq(1'b0, "R9 nothing enabled");
      wr(6'h18, 16'h0010); chk_irq(1'b1, "R9 1Hz enabled");
      wr(6'h14, 16'hFFFF); chk_irq(1'b0, "R9 after clear");

      // R5 disabled: pulses ignored
      wr(6'h10, 16'h0020);
      pulses(500);
      rd(6'h04, 16'h0000, "R5 time held");
      rd(6'h14, 16'h0000, "R5 no ticks");
      wr(6'h10, 16'h00A0);
      wr(6'h00, 16'h0305); wr(6'h04, 16'h003B);
      pulses(31999);
      rd(6'h04, 16'h003B, "R3 R5 one short of 32000");
      pulses(1);
      rd(6'h04, 16'h0000, "R3 32000 second");
      rd(6'h00, 16'h0306, "R4 minute carry");
      rd(6'h14, 16'hFF90, "R6 no alarm on mismatch");

      // R3 38400
      wr(6'h14, 16'hFFFF);
      wr(6'h10, 16'h0040); wr(6'h10, 16'h00C0);
      pulses(38399);
      rd(6'h04, 16'h0000, "R3 one short of 38400");
      pulses(1);
      rd(6'h04, 16'h0001, "R3 38400 second");

      repeat (3) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule